// File: doc/BRIEF.md
# Instruction Fetch Address Decoder with Boot Remap and TCM Overlay

This block sits on the instruction side of a 32-bit processor bus. It examines each fetch address and picks exactly one target: the boot ROM, the SDRAM controller, the asynchronous memory controller, the tightly-coupled instruction memory (TCM) or an error responder. Along with the target it produces the byte offset to present inside that target. The decode result is registered, so it appears one clock after the request.

Two programmable settings shape the map. A 2-bit remap selector chooses what answers in the low 64 MByte of segment 0. A TCM setting gives the physical size, the base and an enable. The TCM window is the physical size rounded up to a power of two, with the base forced to that alignment. While the TCM is enabled, a hit in its window overrides whatever the bus map would have chosen. Software writes both settings through a one-cycle write port. A write affects requests presented on later cycles only.

Top module: `fetch_remap_decoder`

## Requirements
- R1: After reset, out_valid and out_sel are 0, the remap code is 00 and the TCM is disabled, so address 0x0000_0000 selects the boot ROM with offset 0.
- R2: out_sel is one-hot with bit 0 = boot ROM, bit 1 = SDRAM, bit 2 = asynchronous memory, bit 3 = TCM and bit 4 = error. For every cycle with req_valid high, the next cycle has out_valid high and exactly one bit of out_sel set. A cycle with req_valid low is followed by out_valid low and out_sel zero.
- R3: A write with cfg_we=1 and cfg_sel=0 loads the remap code from cfg_wdata[1:0]. For addresses below 0x0400_0000, the codes map as follows: 00 selects the boot ROM, 01 selects SDRAM, 10 selects asynchronous memory and 11 selects error.
- R4: In the remapped low window, the offset is the address modulo the target size. This is 8 KByte for the boot ROM, so its image repeats across the window, and 64 MByte for SDRAM and asynchronous memory.
- R5: Addresses 0x2000_0000 to 0x2FFF_FFFF always select SDRAM, and 0x3000_0000 to 0x3FFF_FFFF always select asynchronous memory. In both cases the offset is address bits 27:0.
- R6: Addresses 0x4000_8000 to 0x4000_9FFF always select the boot ROM with offset address bits 12:0. The rest of 0x4xxx_xxxx selects error.
- R7: Addresses 0x0400_0000 to 0x1FFF_FFFF and 0x5000_0000 to 0xFFFF_FFFF select error. Every error result carries offset 0.
- R8: A write with cfg_we=1 and cfg_sel=1 loads the TCM setting from cfg_wdata. Bits [2:0] give the size in 64 KByte units, and values above 4 are taken as 4. Bit [3] is the enable. Bits [27:16] give the base address bits 27:16 inside segment 0.
- R9: While the TCM is enabled with a nonzero size, an address in its window selects the TCM with offset address modulo the window size. This takes priority over any bus-map result, including remap code 11.
- R10: The window size is the physical size rounded up to the next power of two, so 3 units (192 KByte) occupy 256 KByte.
- R11: A base that is not aligned to the window size is masked down to that alignment.
- R12: With the TCM disabled or set to size 0, every address decodes as in R3 to R7.
- R13: A configuration write is used by requests on the cycles after the write. A request in the same cycle as the write still uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Fetch request strobe |
| req_addr | input | 32 | Fetch byte address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 remap code, 1 TCM setting |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | Registered decode result valid |
| out_sel | output | 5 | One-hot target select (ROM, SDRAM, async, TCM, error) |
| out_offset | output | 32 | Byte offset inside the selected target |

## Verification
A table of addresses runs under each of the four remap codes. Its entries sit on the edges of every region: the last ROM byte and the first byte past it, both ends of the low window, both ends of the ROM alias, the SDRAM and asynchronous segments, and the unmapped gaps. These entries separate a wrong region boundary from a wrong offset mask, and separate the remap-dependent window from the fixed segments. Directed cases then move the TCM window in three ways. Aligned bases, misaligned bases and a 3-unit size show the rounding and base masking, because an address just above the physical size must still hit the TCM. Disabled and zero-size settings show that the TCM has no effect. A TCM window placed over remap code 11 shows that the TCM wins. A write in the same cycle as a request shows which setting that request uses.

// File: rtl/frd_pkg.sv
package frd_pkg;

  localparam int unsigned ADDR_W        = 32;
  localparam int unsigned SEG_AW        = 28;
  localparam int unsigned ROM_AW        = 13;
  localparam int unsigned LOW_AW        = 26;
  localparam int unsigned TCM_UNIT_AW   = 16;
  localparam int unsigned TCM_UNITS_W   = 3;
  localparam int unsigned TCM_MAX_UNITS = 4;
  localparam int unsigned TCM_BASE_W    = SEG_AW - TCM_UNIT_AW;
  localparam int unsigned N_TGT         = 5;

  typedef enum int unsigned {
    TGT_ROM   = 0,
    TGT_SDRAM = 1,
    TGT_ASYNC = 2,
    TGT_TCM   = 3,
    TGT_ERR   = 4
  } tgt_e;

  typedef enum logic [1:0] {
    MAP_ROM   = 2'b00,
    MAP_SDRAM = 2'b01,
    MAP_ASYNC = 2'b10,
    MAP_FAULT = 2'b11
  } remap_e;

  typedef logic [N_TGT-1:0] sel_t;

  typedef struct packed {
    logic                   en;
    logic [TCM_UNITS_W-1:0] units;
    logic [TCM_BASE_W-1:0]  base;
  } tcm_cfg_t;

endpackage

// File: rtl/frd_cfg_regs.sv
module frd_cfg_regs
  import frd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output remap_e            remap_q,
  output tcm_cfg_t          tcm_q
);

  localparam logic [TCM_UNITS_W-1:0] UNITS_CAP = TCM_UNITS_W'(TCM_MAX_UNITS);

  remap_e   remap_d;
  tcm_cfg_t tcm_d;
  logic     remap_en;
  logic     tcm_en;
  logic [TCM_UNITS_W-1:0] units_raw;

  assign remap_en  = cfg_we && !cfg_sel;
  assign tcm_en    = cfg_we &&  cfg_sel;
  assign units_raw = cfg_wdata[TCM_UNITS_W-1:0];

  always_comb begin
    remap_d     = remap_e'(cfg_wdata[1:0]);
    tcm_d.en    = cfg_wdata[TCM_UNITS_W];
    tcm_d.units = (units_raw > UNITS_CAP) ? UNITS_CAP : units_raw;
    tcm_d.base  = cfg_wdata[SEG_AW-1:TCM_UNIT_AW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q <= MAP_ROM;
    end else if (remap_en) begin
      remap_q <= remap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcm_q <= '0;
    end else if (tcm_en) begin
      tcm_q <= tcm_d;
    end
  end

endmodule

// File: rtl/frd_tcm_window.sv
module frd_tcm_window
  import frd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  tcm_cfg_t          cfg,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);

  logic [TCM_UNITS_W:0]  win_units;
  logic [SEG_AW-1:0]     win_mask;
  logic [SEG_AW-1:0]     base_full;
  logic [SEG_AW-1:0]     base_al;
  logic [SEG_AW-1:0]     addr_low;
  logic                  in_seg0;

  // Round the unit count up to a power of two.
  always_comb begin
    win_units = (TCM_UNITS_W+1)'(1);
    for (int i = 0; i < TCM_UNITS_W; i++) begin
      if (win_units < {1'b0, cfg.units}) begin
        win_units = win_units << 1;
      end
    end
  end

  assign win_mask  = (SEG_AW'(win_units) << TCM_UNIT_AW) - SEG_AW'(1);
  assign base_full = {cfg.base, {TCM_UNIT_AW{1'b0}}};
  assign base_al   = base_full & ~win_mask;
  assign addr_low  = addr[SEG_AW-1:0];
  assign in_seg0   = (addr[ADDR_W-1:SEG_AW] == '0);

  assign hit    = cfg.en && (cfg.units != '0) && in_seg0 &&
                  ((addr_low & ~win_mask) == base_al);
  assign offset = ADDR_W'(addr_low & win_mask);

endmodule

// File: rtl/frd_bus_map.sv
module frd_bus_map
  import frd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h4000_8000
) (
  input  logic [ADDR_W-1:0] addr,
  input  remap_e            remap,
  output sel_t              sel,
  output logic [ADDR_W-1:0] offset
);

  localparam int unsigned SEG_W = ADDR_W - SEG_AW;
  localparam logic [ADDR_W-ROM_AW-1:0] ALIAS_TAG = ALIAS_BASE[ADDR_W-1:ROM_AW];

  logic [SEG_W-1:0]  seg;
  logic              low_win;
  logic              alias_hit;
  logic [ADDR_W-1:0] rom_off;
  logic [ADDR_W-1:0] low_off;
  logic [ADDR_W-1:0] seg_off;

  assign seg       = addr[ADDR_W-1:SEG_AW];
  assign low_win   = (addr[SEG_AW-1:LOW_AW] == '0);
  assign alias_hit = (addr[ADDR_W-1:ROM_AW] == ALIAS_TAG);
  assign rom_off   = ADDR_W'(addr[ROM_AW-1:0]);
  assign low_off   = ADDR_W'(addr[LOW_AW-1:0]);
  assign seg_off   = ADDR_W'(addr[SEG_AW-1:0]);

  always_comb begin
    sel    = '0;
    offset = '0;
    sel[TGT_ERR] = 1'b1;
    unique case (seg)
      SEG_W'(0): begin
        if (low_win) begin
          unique case (remap)
            MAP_ROM:   begin sel = '0; sel[TGT_ROM]   = 1'b1; offset = rom_off; end
            MAP_SDRAM: begin sel = '0; sel[TGT_SDRAM] = 1'b1; offset = low_off; end
            MAP_ASYNC: begin sel = '0; sel[TGT_ASYNC] = 1'b1; offset = low_off; end
            default:   ;
          endcase
        end
      end
      SEG_W'(2): begin sel = '0; sel[TGT_SDRAM] = 1'b1; offset = seg_off; end
      SEG_W'(3): begin sel = '0; sel[TGT_ASYNC] = 1'b1; offset = seg_off; end
      SEG_W'(4): begin
        if (alias_hit) begin
          sel = '0; sel[TGT_ROM] = 1'b1; offset = rom_off;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fetch_remap_decoder.sv
module fetch_remap_decoder
  import frd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h4000_8000,
  parameter int unsigned       RST_SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              out_valid,
  output logic [N_TGT-1:0]  out_sel,
  output logic [ADDR_W-1:0] out_offset
);

  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic                       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe[RST_SYNC_STAGES-1];

  remap_e            remap_q;
  tcm_cfg_t          tcm_q;
  logic              tcm_hit;
  logic [ADDR_W-1:0] tcm_off;
  sel_t              bus_sel;
  logic [ADDR_W-1:0] bus_off;

  frd_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .remap_q  (remap_q),
    .tcm_q    (tcm_q)
  );

  frd_tcm_window u_tcm (
    .addr  (req_addr),
    .cfg   (tcm_q),
    .hit   (tcm_hit),
    .offset(tcm_off)
  );

  frd_bus_map #(.ALIAS_BASE(ALIAS_BASE)) u_map (
    .addr  (req_addr),
    .remap (remap_q),
    .sel   (bus_sel),
    .offset(bus_off)
  );

  logic              valid_d;
  sel_t              sel_d;
  logic [ADDR_W-1:0] off_d;

  always_comb begin
    valid_d = req_valid;
    sel_d   = '0;
    off_d   = '0;
    if (req_valid) begin
      if (tcm_hit) begin
        sel_d[TGT_TCM] = 1'b1;
        off_d          = tcm_off;
      end else begin
        sel_d = bus_sel;
        off_d = bus_off;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_valid  <= 1'b0;
      out_sel    <= '0;
      out_offset <= '0;
    end else begin
      out_valid  <= valid_d;
      out_sel    <= sel_d;
      out_offset <= off_d;
    end
  end

endmodule

// File: rtl/frd_checker.sv
module frd_checker
  import frd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              out_valid,
  input logic [N_TGT-1:0]  out_sel,
  input logic [ADDR_W-1:0] out_offset
);

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_sel) == 1));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_sel == '0));

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  a_r7_err_offset: assert property (@(posedge clk) disable iff (!rst_n)
    out_sel[TGT_ERR] |-> (out_offset == '0));

  a_r4_rom_offset: assert property (@(posedge clk) disable iff (!rst_n)
    out_sel[TGT_ROM] |-> (out_offset < (ADDR_W'(1) << ROM_AW)));

  a_r5_sdram_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:28] == 4'h2) |=>
      (out_sel[TGT_SDRAM] && out_offset == {4'h0, $past(req_addr[27:0])}));

  a_r6_rom_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:13] == 19'h2_0004) |=>
      (out_sel[TGT_ROM] && out_offset == ADDR_W'($past(req_addr[12:0]))));

endmodule

bind fetch_remap_decoder frd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .out_valid (out_valid),
  .out_sel   (out_sel),
  .out_offset(out_offset)
);

// File: tb/fetch_remap_decoder_tb.sv
module fetch_remap_decoder_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        cfg_we;
  logic        cfg_sel;
  logic [31:0] cfg_wdata;
  logic        out_valid;
  logic [4:0]  out_sel;
  logic [31:0] out_offset;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  localparam logic [4:0] S_ROM = 5'h01, S_SDR = 5'h02, S_ASY = 5'h04,
                         S_TCM = 5'h08, S_ERR = 5'h10;

  fetch_remap_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_sel(out_sel), .out_offset(out_offset)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {remap, addr, sel, offset}
  localparam int NV = 22;
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 32'h0000_0000, S_ROM, 32'h0000_0000},
    {2'd0, 32'h0000_1FFF, S_ROM, 32'h0000_1FFF},
    {2'd0, 32'h0000_2004, S_ROM, 32'h0000_0004},
    {2'd0, 32'h03FF_FFFC, S_ROM, 32'h0000_1FFC},
    {2'd0, 32'h0400_0000, S_ERR, 32'h0000_0000},
    {2'd0, 32'h1234_5678, S_ERR, 32'h0000_0000},
    {2'd0, 32'h2000_0010, S_SDR, 32'h0000_0010},
    {2'd0, 32'h2FFF_FFFF, S_SDR, 32'h0FFF_FFFF},
    {2'd0, 32'h3ABC_0000, S_ASY, 32'h0ABC_0000},
    {2'd0, 32'h4000_8000, S_ROM, 32'h0000_0000},
    {2'd0, 32'h4000_9FFF, S_ROM, 32'h0000_1FFF},
    {2'd0, 32'h4000_7FFF, S_ERR, 32'h0000_0000},
    {2'd0, 32'h4000_A000, S_ERR, 32'h0000_0000},
    {2'd0, 32'h5000_0000, S_ERR, 32'h0000_0000},
    {2'd0, 32'hFFFF_FFFF, S_ERR, 32'h0000_0000},
    {2'd1, 32'h0000_2004, S_SDR, 32'h0000_2004},
    {2'd1, 32'h03FF_FFFF, S_SDR, 32'h03FF_FFFF},
    {2'd1, 32'h0400_0000, S_ERR, 32'h0000_0000},
    {2'd2, 32'h0123_4560, S_ASY, 32'h0123_4560},
    {2'd2, 32'h4000_8010, S_ROM, 32'h0000_0010},
    {2'd3, 32'h0000_0000, S_ERR, 32'h0000_0000},
    {2'd3, 32'h2000_0000, S_SDR, 32'h0000_0000}
  };

  task automatic check(input string req, input logic exp_v,
                       input logic [4:0] exp_s, input logic [31:0] exp_o);
    checks = checks + 1;
    if (out_valid !== exp_v || out_sel !== exp_s || out_offset !== exp_o) begin
      errors = errors + 1;
      $display("FAIL %s: actual v=%0b sel=%h off=%h expected v=%0b sel=%h off=%h",
               req, out_valid, out_sel, out_offset, exp_v, exp_s, exp_o);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] tcm_word(input logic en, input logic [2:0] units,
                                           input logic [31:0] base);
    return (base & 32'h0FFF_0000) | {28'h0, en, units};
  endfunction

  task automatic fetch(input string req, input logic [31:0] a,
                       input logic [4:0] exp_s, input logic [31:0] exp_o);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, 1'b1, exp_s, exp_o);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 reset outputs", 1'b0, 5'h00, 32'h0);
    fetch("R1 boot ROM at zero", 32'h0000_0000, S_ROM, 32'h0);

    // R2 idle cycle
    @(negedge clk);
    check("R2 idle", 1'b0, 5'h00, 32'h0);

    // Table walk: R3 R4 R5 R6 R7 R12
    for (int i = 0; i < NV; i++) begin
      logic [1:0] rm;
      rm = VEC[i][70:69];
      cfg_write(1'b0, {30'h0, rm});
      fetch($sformatf("R3-map vector %0d", i), VEC[i][68:37], VEC[i][36:32], VEC[i][31:0]);
    end

    // R13 same-cycle write uses old code
    cfg_write(1'b0, 32'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h1;
    req_valid = 1'b1; req_addr = 32'h0000_0100;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R13 old remap used", 1'b1, S_ROM, 32'h100);
    fetch("R13 new remap used", 32'h0000_0100, S_SDR, 32'h100);

    // R8 R9 TCM 64K window at 0x1_0000, remap 00
    cfg_write(1'b0, 32'h0);
    cfg_write(1'b1, tcm_word(1'b1, 3'd1, 32'h0001_0000));
    fetch("R9 tcm hit", 32'h0001_0004, S_TCM, 32'h4);
    fetch("R9 above window", 32'h0002_0000, S_ROM, 32'h0);
    fetch("R9 below window", 32'h0000_FFFF, S_ROM, 32'h1FFF);

    // R10 rounding 3 units -> 256K
    cfg_write(1'b1, tcm_word(1'b1, 3'd3, 32'h0004_0000));
    fetch("R10 past physical size", 32'h0007_FFF0, S_TCM, 32'h3_FFF0);
    fetch("R10 window end", 32'h0008_0000, S_ROM, 32'h0);

    // R11 misaligned base masked
    cfg_write(1'b1, tcm_word(1'b1, 3'd3, 32'h0005_0000));
    fetch("R11 masked base", 32'h0004_0000, S_TCM, 32'h0);

    // R9 over SDRAM remap
    cfg_write(1'b0, 32'h1);
    cfg_write(1'b1, tcm_word(1'b1, 3'd2, 32'h0300_0000));
    fetch("R9 over sdram", 32'h0301_0008, S_TCM, 32'h1_0008);
    fetch("R9 outside sdram", 32'h0302_0000, S_SDR, 32'h0302_0000);

    // R9 priority over remap fault
    cfg_write(1'b0, 32'h3);
    cfg_write(1'b1, tcm_word(1'b1, 3'd1, 32'h0000_0000));
    fetch("R9 over fault", 32'h0000_0010, S_TCM, 32'h10);
    fetch("R9 fault outside", 32'h0001_0000, S_ERR, 32'h0);

    // R8 size clamp 7 -> 4 units
    cfg_write(1'b0, 32'h0);
    cfg_write(1'b1, tcm_word(1'b1, 3'd7, 32'h0000_0000));
    fetch("R8 clamp in", 32'h0003_FFFF, S_TCM, 32'h3_FFFF);
    fetch("R8 clamp out", 32'h0004_0000, S_ROM, 32'h0);

    // R12 disabled and zero size
    cfg_write(1'b1, tcm_word(1'b0, 3'd1, 32'h0004_0000));
    fetch("R12 disabled", 32'h0004_0000, S_ROM, 32'h0);
    cfg_write(1'b1, tcm_word(1'b1, 3'd0, 32'h0004_0000));
    fetch("R12 zero size", 32'h0004_0000, S_ROM, 32'h0);

    // R1 reset returns defaults
    cfg_write(1'b0, 32'h2);
    cfg_write(1'b1, tcm_word(1'b1, 3'd1, 32'h0000_0000));
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 outputs in reset", 1'b0, 5'h00, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fetch("R1 defaults after reset", 32'h0000_0040, S_ROM, 32'h40);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule